// File: doc/BRIEF.md
# Register write command stream engine

The engine executes a queue of register-write instructions held in memory. Software sets a start address (head), then writes an end address (tail) while the engine is enabled. The engine then fetches 32-bit words from a memory read port, one at a time, from the current head up to the tail. It decodes each 8-byte instruction and issues the result on a register write port that carries a 4-bit byte strobe.

Four instruction forms exist: a no-op, a direct full-word write, a masked write limited to chosen bytes, and an indexed burst. The indexed burst writes a counted run of data words to one register. Zero padding that keeps instructions and the tail aligned is consumed without effect.

A busy flag and the current head show progress. Dropping the enable aborts a run. An unknown opcode stops the engine and raises a sticky error.

Top module: `regwr_stream_engine`

## Requirements
- R1: An instruction is two words on an 8-byte boundary: the lower word is data, the upper word holds the opcode in bits [31:24] and the register offset in bits [19:0]; opcode 0x01 writes the data to that offset with strobe 4'hF.
- R2: Opcode 0x02 writes the data with the byte strobe taken from upper-word bits [23:20], including strobe 0.
- R3: Opcode 0x00 (and an all-zero instruction pair, as used for tail fill) issues no write and consumes 8 bytes.
- R4: Opcode 0x09 takes a count N from the lower word; the next N words are each written, in order and with strobe 4'hF, to the one offset; N = 0 issues no write.
- R5: When an indexed burst ends on an odd word position, the following pad word is skipped without a read, and the next instruction decodes correctly.
- R6: After reset the engine is idle. A tail write while enabled, with the tail different from the head, raises busy on the next cycle. With the tail equal to the head, or with the enable low, no run starts.
- R7: A run ends when the current head reaches the tail at an instruction boundary. Busy then drops and the current head equals the tail.
- R8: Clearing the enable during a run drops busy and the write request after the next clock edge.
- R9: An unknown opcode sets a sticky error, ends the run, and blocks further writes and restarts until the enable is cleared; clearing the enable also clears the error.
- R10: A write request holds its valid, address, data and strobe until accepted; only one write is outstanding.
- R11: Memory read requests address the current head, are word aligned, stay below the tail, and hold until granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run enable; low aborts and clears error |
| head_wr_i | input | 1 | Load head (when idle) |
| head_addr_i | input | AW | Head byte address |
| tail_wr_i | input | 1 | Load tail; starts a run when enabled |
| tail_addr_i | input | AW | Tail byte address |
| busy_o | output | 1 | Run in progress |
| err_o | output | 1 | Sticky unknown-opcode error |
| cur_head_o | output | AW | Address of the next word to fetch |
| mem_req_o | output | 1 | Read request valid |
| mem_addr_o | output | AW | Read byte address |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| reg_wr_valid_o | output | 1 | Register write valid |
| reg_wr_ready_i | input | 1 | Register write accepted |
| reg_wr_addr_o | output | RW | Register offset |
| reg_wr_data_o | output | 32 | Write data |
| reg_wr_strb_o | output | 4 | Byte strobe |

## Verification
Busy is due one cycle after the tail-write edge, and it is sampled at the falling edge that follows. An abort is checked at the first falling edge after the edge that sees the enable low. Each write is compared at the falling edge where valid and ready are both high, before the accepting edge, against a list the bench builds while it encodes the program. Held writes are compared with the previous falling edge. End-of-run values (write count, head equal to tail, error) are read only after busy has been seen low. Grant and ready follow fixed periodic patterns, so the stall paths are covered.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_WR  = 8'h01;
  localparam logic [7:0] OP_MWR = 8'h02;
  localparam logic [7:0] OP_IDX = 8'h09;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_WR} state_e;
  typedef enum logic [1:0] {WK_LO, WK_HI, WK_DAT} word_e;
  typedef enum logic [2:0] {K_NOP, K_WR, K_IDX, K_BAD} kind_e;
endpackage

// File: rtl/regwr_decode.sv
module regwr_decode
  import regwr_pkg::*;
#(
  parameter int RW = 20
) (
  input  logic [31:0]   hi_i,
  output kind_e         kind_o,
  output logic [RW-1:0] reg_o,
  output logic [3:0]    strb_o
);
  logic [7:0] op;
  assign op    = hi_i[31:24];
  assign reg_o = hi_i[RW-1:0];

  always_comb begin
    kind_o = K_BAD;
    strb_o = 4'hF;
    case (op)
      OP_NOP: kind_o = K_NOP;
      OP_WR:  kind_o = K_WR;
      OP_MWR: begin kind_o = K_WR; strb_o = hi_i[23:20]; end
      OP_IDX: kind_o = K_IDX;
      default: kind_o = K_BAD;
    endcase
  end
endmodule

// File: rtl/regwr_ptr.sv
module regwr_ptr #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idle_i,
  input  logic          head_wr_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic          tail_wr_i,
  input  logic [AW-1:0] tail_addr_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] tail_o,
  output logic          at_tail_o,
  output logic          near_tail_o,
  output logic          odd_o
);
  localparam logic [AW-1:0] ALIGN_M = ~AW'(7);
  localparam logic [AW-1:0] WSTEP   = AW'(4);

  logic [AW-1:0] cur_q, tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      tail_q <= '0;
    end else begin
      if (head_wr_i && idle_i) cur_q <= head_addr_i & ALIGN_M;
      else if (adv_i)          cur_q <= cur_q + WSTEP;
      if (tail_wr_i)           tail_q <= tail_addr_i & ALIGN_M;
    end
  end

  assign cur_o       = cur_q;
  assign tail_o      = tail_q;
  assign at_tail_o   = (cur_q == tail_q);
  assign near_tail_o = ((cur_q + WSTEP) == tail_q);
  assign odd_o       = cur_q[2];
endmodule

// File: rtl/regwr_stream_engine.sv
module regwr_stream_engine
  import regwr_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 20,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          head_wr_i,
  input  logic [AW-1:0] head_addr_i,
  input  logic          tail_wr_i,
  input  logic [AW-1:0] tail_addr_i,
  output logic          busy_o,
  output logic          err_o,
  output logic [AW-1:0] cur_head_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          reg_wr_valid_o,
  input  logic          reg_wr_ready_i,
  output logic [RW-1:0] reg_wr_addr_o,
  output logic [31:0]   reg_wr_data_o,
  output logic [3:0]    reg_wr_strb_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] ALIGN_M = ~AW'(7);

  state_e        state_q;
  word_e         wk_q;
  logic [31:0]   lo_q, wdata_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] waddr_q;
  logic [3:0]    wstrb_q;
  logic          err_q;

  kind_e         dkind;
  logic [RW-1:0] dreg;
  logic [3:0]    dstrb;
  logic [AW-1:0] cur, tail;
  logic          at_tail, near_tail, odd;
  logic          go, wr_done, last_dat, adv, rsp;

  regwr_decode #(.RW(RW)) u_dec (
    .hi_i(mem_rdata_i), .kind_o(dkind), .reg_o(dreg), .strb_o(dstrb)
  );

  regwr_ptr #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni,
    .idle_i(state_q == ST_IDLE),
    .head_wr_i, .head_addr_i, .tail_wr_i, .tail_addr_i,
    .adv_i(adv),
    .cur_o(cur), .tail_o(tail),
    .at_tail_o(at_tail), .near_tail_o(near_tail), .odd_o(odd)
  );

  assign go       = tail_wr_i && enable_i && !err_q && ((tail_addr_i & ALIGN_M) != cur);
  assign rsp      = (state_q == ST_RSP) && mem_rvalid_i;
  assign wr_done  = (state_q == ST_WR) && reg_wr_ready_i;
  assign last_dat = (wk_q == WK_DAT) && (cnt_q == CNT_ONE);
  // pad skip advances the head without a read
  assign adv      = enable_i && (rsp || (wr_done && last_dat && odd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wk_q    <= WK_LO;
      lo_q    <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
      waddr_q <= '0;
      wstrb_q <= '0;
      err_q   <= 1'b0;
    end else if (!enable_i) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (go) begin state_q <= ST_REQ; wk_q <= WK_LO; end
        ST_REQ:  if (mem_gnt_i) state_q <= ST_RSP;
        ST_RSP: if (mem_rvalid_i) begin
          case (wk_q)
            WK_LO: begin lo_q <= mem_rdata_i; wk_q <= WK_HI; state_q <= ST_REQ; end
            WK_HI: begin
              wk_q <= WK_LO;
              case (dkind)
                K_WR: begin
                  waddr_q <= dreg; wdata_q <= lo_q; wstrb_q <= dstrb;
                  state_q <= ST_WR;
                end
                K_IDX: if (lo_q[CW-1:0] == '0) begin
                  state_q <= near_tail ? ST_IDLE : ST_REQ;
                end else begin
                  cnt_q <= lo_q[CW-1:0]; waddr_q <= dreg; wstrb_q <= 4'hF;
                  wk_q <= WK_DAT; state_q <= ST_REQ;
                end
                K_NOP: state_q <= near_tail ? ST_IDLE : ST_REQ;
                default: begin err_q <= 1'b1; state_q <= ST_IDLE; end
              endcase
            end
            default: begin wdata_q <= mem_rdata_i; state_q <= ST_WR; end
          endcase
        end
        default: if (reg_wr_ready_i) begin
          if (wk_q == WK_DAT && !last_dat) begin
            cnt_q <= cnt_q - CNT_ONE; state_q <= ST_REQ;
          end else if (wk_q == WK_DAT) begin
            wk_q    <= WK_LO;
            state_q <= (odd ? near_tail : at_tail) ? ST_IDLE : ST_REQ;
          end else begin
            state_q <= at_tail ? ST_IDLE : ST_REQ;
          end
        end
      endcase
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign err_o          = err_q;
  assign cur_head_o     = cur;
  assign mem_req_o      = (state_q == ST_REQ);
  assign mem_addr_o     = cur;
  assign reg_wr_valid_o = (state_q == ST_WR);
  assign reg_wr_addr_o  = waddr_q;
  assign reg_wr_data_o  = wdata_q;
  assign reg_wr_strb_o  = wstrb_q;

  a_r10_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_valid_o && !reg_wr_ready_i && enable_i) |=>
      (reg_wr_valid_o && $stable(reg_wr_addr_o) && $stable(reg_wr_data_o) && $stable(reg_wr_strb_o)));

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i && enable_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r8_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!busy_o && !reg_wr_valid_o));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && enable_i) |=> (err_o && !busy_o));

  a_r7_end_at_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(enable_i) && !err_o) |-> (cur_head_o == tail));
endmodule

// File: tb/regwr_stream_engine_bench.sv
module regwr_stream_engine_bench;
  localparam int AW = 16;
  localparam int RW = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, enable, head_wr, tail_wr, gnt, rvalid, ready;
  logic [AW-1:0] head_addr, tail_addr;
  logic [31:0] rdata;
  logic busy, err, mem_req, wr_valid;
  logic [AW-1:0] cur_head, mem_addr;
  logic [RW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] wr_strb;

  regwr_stream_engine #(.AW(AW), .RW(RW), .CW(16)) u_regwr_stream_engine (
    .clk_i(clk), .rst_ni, .enable_i(enable),
    .head_wr_i(head_wr), .head_addr_i(head_addr),
    .tail_wr_i(tail_wr), .tail_addr_i(tail_addr),
    .busy_o(busy), .err_o(err), .cur_head_o(cur_head),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(gnt),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .reg_wr_valid_o(wr_valid), .reg_wr_ready_i(ready),
    .reg_wr_addr_o(wr_addr), .reg_wr_data_o(wr_data), .reg_wr_strb_o(wr_strb)
  );

  logic [31:0] mem [0:255];
  logic [RW-1:0] ex_addr [0:255];
  logic [31:0] ex_data [0:255];
  logic [3:0] ex_strb [0:255];
  int n_exp, obs_n, wp, n_chk, n_err, cyc;
  logic [AW-1:0] cur_tail;
  logic rd_ok, stall_q, done;
  logic [55:0] stall_v;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory and slave models: periodic grant/ready stalls, read data one cycle after grant
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    rvalid <= mem_req && gnt;
    rdata  <= mem[mem_addr[9:2]];
    gnt    <= (cyc % 3) != 1;
    ready  <= (cyc % 4) != 2;
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (stall_q && enable) begin
        chk("R10 held write", {7'd0, wr_valid, wr_addr, wr_data, wr_strb}, {8'd1, stall_v});
      end
      stall_q <= wr_valid && !ready;
      stall_v <= {wr_addr, wr_data, wr_strb};
      if (mem_req && gnt && (mem_addr[1:0] != 2'b00 || mem_addr >= cur_tail)) rd_ok <= 1'b0;
      if (wr_valid && ready) begin
        chk("R1/R2/R4 write addr+strb", {40'd0, wr_addr, wr_strb}, {40'd0, ex_addr[obs_n[7:0]], ex_strb[obs_n[7:0]]});
        chk("R1/R2/R4 write data", {32'd0, wr_data}, {32'd0, ex_data[obs_n[7:0]]});
        obs_n <= obs_n + 1;
      end
    end
  end

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    wp = 0; n_exp = 0; obs_n = 0;
  endtask

  task automatic put(input logic [31:0] w);
    mem[wp[7:0]] = w; wp++;
  endtask

  task automatic push(input logic [RW-1:0] a, input logic [31:0] d, input logic [3:0] s);
    ex_addr[n_exp[7:0]] = a; ex_data[n_exp[7:0]] = d; ex_strb[n_exp[7:0]] = s; n_exp++;
  endtask

  task automatic direct(input logic [RW-1:0] a, input logic [31:0] d);
    put(d); put({8'h01, 4'h0, a}); push(a, d, 4'hF);
  endtask

  task automatic masked(input logic [RW-1:0] a, input logic [31:0] d, input logic [3:0] s);
    put(d); put({8'h02, s, a}); push(a, d, s);
  endtask

  task automatic indexed(input logic [RW-1:0] a, input int n, input logic [31:0] base);
    put(n); put({8'h09, 4'h0, a});
    for (int i = 0; i < n; i++) begin put(base + i); push(a, base + i, 4'hF); end
    if (wp % 2 == 1) put(32'h0);
  endtask

  function automatic logic [AW-1:0] tail_of();
    return AW'(((wp + 15) / 16) * 64);
  endfunction

  task automatic start(input logic [AW-1:0] t);
    @(negedge clk); head_wr = 1'b1; head_addr = '0;
    @(negedge clk); head_wr = 1'b0; tail_wr = 1'b1; tail_addr = t; cur_tail = t; rd_ok = 1'b1;
    @(negedge clk); tail_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic run_prog(input string tag);
    logic [AW-1:0] t;
    t = tail_of();
    start(t);
    chk("R6 busy after tail write", {63'd0, busy}, 64'd1);
    wait_idle();
    @(negedge clk);
    chk({tag, " R7 write count"}, obs_n, n_exp);
    chk("R7 head equals tail", {48'd0, cur_head}, {48'd0, t});
    chk("R7 idle, no error", {62'd0, busy, err}, 64'd0);
    chk("R11 read addresses", {63'd0, rd_ok}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL R7 watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    done = 1'b0; n_chk = 0; n_err = 0; cyc = 0; stall_q = 1'b0; stall_v = '0;
    rst_ni = 1'b0; enable = 1'b0; head_wr = 1'b0; tail_wr = 1'b0;
    head_addr = '0; tail_addr = '0; cur_tail = '0; rd_ok = 1'b1;
    clear_prog();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 reset idle", {60'd0, busy, err, mem_req, wr_valid}, 64'd0);
    enable = 1'b1;

    // R1 direct writes, R3 no-ops and zero tail fill
    clear_prog();
    direct(20'h00005, 32'hDEADBEEF); put(0); put(0);
    direct(20'hABCDE, 32'h12345678); put(0); put(0); put(0); put(0);
    direct(20'h00005, 32'hCAFEF00D);
    run_prog("R1 R3");

    // R2 every strobe value
    clear_prog();
    for (int s = 0; s < 16; s++) masked(RW'(s), 32'h11223344 ^ (s * 32'h01010101), 4'(s));
    run_prog("R2");

    // R4 counts 0..5, R5 pad skip checked by the following direct write
    clear_prog();
    for (int n = 0; n < 6; n++) begin
      indexed(RW'(20'h100 + n), n, 32'(n << 8));
      direct(20'h00040, 32'(n));
    end
    run_prog("R4 R5");

    // R6 tail equal to head does not start
    clear_prog();
    direct(20'h1, 32'h1);
    start('0);
    chk("R6 tail==head stays idle", {63'd0, busy}, 64'd0);
    // R6 tail write with enable low does not start
    enable = 1'b0;
    start(AW'(64));
    repeat (4) @(negedge clk);
    chk("R6 disabled stays idle", {63'd0, busy}, 64'd0);
    chk("R6 disabled no write", obs_n, 0);
    enable = 1'b1;

    // R8 abort mid-run
    clear_prog();
    for (int i = 0; i < 80; i++) put(0);
    start(tail_of());
    repeat (10) @(negedge clk);
    chk("R8 busy before abort", {63'd0, busy}, 64'd1);
    enable = 1'b0;
    @(negedge clk);
    chk("R8 abort drops busy", {62'd0, busy, wr_valid}, 64'd0);
    chk("R8 stopped early", {63'd0, cur_head < AW'(320)}, 64'd1);
    enable = 1'b1;
    repeat (3) @(negedge clk);

    // R9 unknown opcode
    clear_prog();
    direct(20'h00003, 32'h000000AA);
    put(32'h0); put(32'h55000007);
    put(32'hBB); put({8'h01, 24'h000004});
    start(tail_of());
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R9 error set", {63'd0, err}, 64'd1);
    chk("R9 no write after bad op", obs_n, 1);
    start(tail_of());
    chk("R9 no restart while error", {62'd0, busy, err}, 64'd1);
    enable = 1'b0;
    @(negedge clk);
    chk("R9 enable low clears error", {63'd0, err}, 64'd0);
    enable = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule